// File: doc/BRIEF.md
# Timer Control and Interrupt Status Bank

This block holds the shared control state of an eight-channel timer unit: a per-channel counter-enable vector, a per-channel clock-halt vector, an interrupt-flag vector and an interrupt-mask vector. Each vector can be read at its own address. It also has one alias address that sets bits and one that clears bits. Software can therefore start, halt, acknowledge or unmask a single channel in one write, with no read-modify-write.

The channels report two kinds of events: a full-period match and a half-period match. A full match sets the flag bit in the lower half of the flag word. A half match sets the bit in the upper half. A combined interrupt line is driven from a register. It goes high when any flag is set and its mask bit is clear. The enable and halt vectors go straight out to the channel counters.

The bus port is a plain single-cycle write strobe with combinational read data. Address decoding sorts each access into a target vector and an access kind: base, set alias, clear alias or unmapped. A write with the base kind changes nothing. A write with the set or clear kind changes bits. A read of any of the three kinds returns the vector.

Top module: `timer_ctl_bank`

## Requirements
- R1: After reset, the enable, halt and flag vectors read zero, the mask vector reads 0x00FF00FF (every implemented bit masked), and irq is 0.
- R2: Byte addresses are: enable at 0x00 (set 0x04, clear 0x08); halt at 0x0C (set 0x1C, clear 0x2C); flag at 0x10 (set 0x14, clear 0x18); mask at 0x20 (set 0x24, clear 0x28).
- R3: A write to a set alias sets every implemented bit whose write-data bit is 1. All other bits are unchanged. The new value is visible after the write's clock edge.
- R4: A write to a clear alias clears every bit whose write-data bit is 1. All other bits are unchanged.
- R5: A write to a base address leaves that vector unchanged.
- R6: A read of the base, set or clear address of a vector returns that vector, zero-extended. Flag and mask bits 8..15 and 24..31 always read 0. Any other address reads 0.
- R7: evt_full[n] high at a clock edge sets flag bit n. evt_half[n] high at a clock edge sets flag bit n+16.
- R8: When a channel event and a software clear of the same flag bit occur at the same edge, the bit ends up set.
- R9: irq at each edge becomes the OR over all bits of (flag AND NOT mask) as held before that edge, so it lags the vectors by one cycle.
- R10: chan_en and chan_stop always equal the low eight bits of the enable and halt vectors.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Write strobe for the current address |
| bus_addr | input | AW (8) | Byte address |
| bus_wdata | input | DW (32) | Write data, one bit per vector bit |
| bus_rdata | output | DW (32) | Read data for bus_addr, combinational |
| evt_full | input | NCH (8) | Full-period match event per channel |
| evt_half | input | NCH (8) | Half-period match event per channel |
| chan_en | output | NCH (8) | Counter enable per channel |
| chan_stop | output | NCH (8) | Clock halt per channel |
| irq | output | 1 | Registered combined interrupt |

## Verification
The properties assume that bus_addr, bus_wdata, bus_wr and the event inputs are stable around each rising edge. They also assume that a single write targets one address per cycle, so a set and a clear of the same vector never land together. The stimulus holds to these assumptions: every input changes only on the falling edge, and there is at most one write per cycle. Events arrive on random cycles. They sometimes coincide with clear-alias writes to the flag vector, which is the case the set-wins property covers. Unmapped addresses appear in the random address pool for reads and writes.

// File: rtl/timer_ctl_pkg.sv
package timer_ctl_pkg;

    typedef enum logic [1:0] {
        V_EN   = 2'd0,
        V_STOP = 2'd1,
        V_FLAG = 2'd2,
        V_MASK = 2'd3
    } vsel_e;

    typedef enum logic [1:0] {
        A_NONE = 2'd0,
        A_BASE = 2'd1,
        A_SET  = 2'd2,
        A_CLR  = 2'd3
    } acc_e;

    typedef struct packed {
        vsel_e sel;
        acc_e  acc;
    } dec_t;

    // offsets decoded by software drivers; kept fixed
    localparam logic [7:0] OFS_EN_BASE   = 8'h00;
    localparam logic [7:0] OFS_EN_SET    = 8'h04;
    localparam logic [7:0] OFS_EN_CLR    = 8'h08;
    localparam logic [7:0] OFS_STOP_BASE = 8'h0C;
    localparam logic [7:0] OFS_STOP_SET  = 8'h1C;
    localparam logic [7:0] OFS_STOP_CLR  = 8'h2C;
    localparam logic [7:0] OFS_FLAG_BASE = 8'h10;
    localparam logic [7:0] OFS_FLAG_SET  = 8'h14;
    localparam logic [7:0] OFS_FLAG_CLR  = 8'h18;
    localparam logic [7:0] OFS_MASK_BASE = 8'h20;
    localparam logic [7:0] OFS_MASK_SET  = 8'h24;
    localparam logic [7:0] OFS_MASK_CLR  = 8'h28;

endpackage

// File: rtl/timer_ctl_decode.sv
module timer_ctl_decode
    import timer_ctl_pkg::*;
#(
    parameter int AW = 8
) (
    input  logic [AW-1:0] addr,
    output dec_t          dec
);

    always_comb begin
        dec.sel = V_EN;
        dec.acc = A_NONE;
        unique case (addr)
            AW'(OFS_EN_BASE):   begin dec.sel = V_EN;   dec.acc = A_BASE; end
            AW'(OFS_EN_SET):    begin dec.sel = V_EN;   dec.acc = A_SET;  end
            AW'(OFS_EN_CLR):    begin dec.sel = V_EN;   dec.acc = A_CLR;  end
            AW'(OFS_STOP_BASE): begin dec.sel = V_STOP; dec.acc = A_BASE; end
            AW'(OFS_STOP_SET):  begin dec.sel = V_STOP; dec.acc = A_SET;  end
            AW'(OFS_STOP_CLR):  begin dec.sel = V_STOP; dec.acc = A_CLR;  end
            AW'(OFS_FLAG_BASE): begin dec.sel = V_FLAG; dec.acc = A_BASE; end
            AW'(OFS_FLAG_SET):  begin dec.sel = V_FLAG; dec.acc = A_SET;  end
            AW'(OFS_FLAG_CLR):  begin dec.sel = V_FLAG; dec.acc = A_CLR;  end
            AW'(OFS_MASK_BASE): begin dec.sel = V_MASK; dec.acc = A_BASE; end
            AW'(OFS_MASK_SET):  begin dec.sel = V_MASK; dec.acc = A_SET;  end
            AW'(OFS_MASK_CLR):  begin dec.sel = V_MASK; dec.acc = A_CLR;  end
            default:            begin dec.sel = V_EN;   dec.acc = A_NONE; end
        endcase
    end

endmodule

// File: rtl/timer_ctl_vec.sv
module timer_ctl_vec #(
    parameter int              DW    = 32,
    parameter logic [DW-1:0]   VALID = '1,
    parameter logic [DW-1:0]   RSTV  = '0
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [DW-1:0] sw_set,
    input  logic [DW-1:0] sw_clr,
    input  logic [DW-1:0] hw_set,
    output logic [DW-1:0] q
);

    // hardware and software sets are applied after the clear: set wins
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= RSTV & VALID;
        else        q <= ((q & ~sw_clr) | sw_set | hw_set) & VALID;
    end

endmodule

// File: rtl/timer_ctl_bank.sv
module timer_ctl_bank
    import timer_ctl_pkg::*;
#(
    parameter int NCH      = 8,
    parameter int HALF_POS = 16,
    parameter int AW       = 8,
    parameter int DW       = 32
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           bus_wr,
    input  logic [AW-1:0]  bus_addr,
    input  logic [DW-1:0]  bus_wdata,
    output logic [DW-1:0]  bus_rdata,
    input  logic [NCH-1:0] evt_full,
    input  logic [NCH-1:0] evt_half,
    output logic [NCH-1:0] chan_en,
    output logic [NCH-1:0] chan_stop,
    output logic           irq
);

    localparam int            NVEC      = 4;
    localparam logic [DW-1:0] CH_BITS   = DW'((64'd1 << NCH) - 64'd1);
    localparam logic [DW-1:0] HALF_BITS = CH_BITS << HALF_POS;
    localparam logic [DW-1:0] IRQ_BITS  = CH_BITS | HALF_BITS;

    dec_t          dec;
    logic [DW-1:0] vq     [NVEC];
    logic [DW-1:0] set_m  [NVEC];
    logic [DW-1:0] clr_m  [NVEC];
    logic [DW-1:0] hw_m   [NVEC];
    logic [DW-1:0] flag_q;
    logic [DW-1:0] mask_q;
    logic          irq_q;

    timer_ctl_decode #(.AW(AW)) u_dec (
        .addr (bus_addr),
        .dec  (dec)
    );

    for (genvar g = 0; g < NVEC; g++) begin : g_vec
        localparam logic [DW-1:0] VALID = (g >= 2) ? IRQ_BITS : CH_BITS;
        localparam logic [DW-1:0] RSTV  = (g == 3) ? IRQ_BITS : '0;

        always_comb begin
            set_m[g] = '0;
            clr_m[g] = '0;
            if (bus_wr && dec.sel == vsel_e'(g)) begin
                if (dec.acc == A_SET) set_m[g] = bus_wdata;
                if (dec.acc == A_CLR) clr_m[g] = bus_wdata;
            end
            if (g == 2) hw_m[g] = (DW'(evt_half) << HALF_POS) | DW'(evt_full);
            else        hw_m[g] = '0;
        end

        timer_ctl_vec #(.DW(DW), .VALID(VALID), .RSTV(RSTV)) u_vec (
            .clk    (clk),
            .rst_n  (rst_n),
            .sw_set (set_m[g]),
            .sw_clr (clr_m[g]),
            .hw_set (hw_m[g]),
            .q      (vq[g])
        );
    end

    assign flag_q = vq[V_FLAG];
    assign mask_q = vq[V_MASK];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) irq_q <= 1'b0;
        else        irq_q <= |(flag_q & ~mask_q);
    end

    always_comb begin
        bus_rdata = '0;
        if (dec.acc != A_NONE) bus_rdata = vq[dec.sel];
    end

    assign chan_en   = vq[V_EN][NCH-1:0];
    assign chan_stop = vq[V_STOP][NCH-1:0];
    assign irq       = irq_q;

endmodule

// File: rtl/timer_ctl_bank_chk.sv
module timer_ctl_bank_chk #(
    parameter int NCH      = 8,
    parameter int HALF_POS = 16,
    parameter int AW       = 8,
    parameter int DW       = 32
) (
    input logic           clk,
    input logic           rst_n,
    input logic           bus_wr,
    input logic [AW-1:0]  bus_addr,
    input logic [DW-1:0]  bus_wdata,
    input logic [NCH-1:0] evt_full,
    input logic [NCH-1:0] evt_half,
    input logic [NCH-1:0] chan_en,
    input logic [NCH-1:0] chan_stop,
    input logic           irq,
    input logic [DW-1:0]  flag_q,
    input logic [DW-1:0]  mask_q
);

    localparam logic [DW-1:0] CH_BITS  = DW'((64'd1 << NCH) - 64'd1);
    localparam logic [DW-1:0] IRQ_BITS = CH_BITS | (CH_BITS << HALF_POS);

    p_flag_set_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == AW'(8'h14)) |=>
        ((flag_q & $past(bus_wdata & IRQ_BITS)) == $past(bus_wdata & IRQ_BITS)));

    p_en_clear_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == AW'(8'h08)) |=>
        ((chan_en & $past(bus_wdata[NCH-1:0])) == '0));

    p_stop_base_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == AW'(8'h0C)) |=> $stable(chan_stop));

    p_half_event_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (|evt_half) |=>
        ((flag_q[HALF_POS +: NCH] & $past(evt_half)) == $past(evt_half)));

    p_event_wins_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (|evt_full) |=>
        ((flag_q[NCH-1:0] & $past(evt_full)) == $past(evt_full)));

    p_irq_lag_r9: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (irq == $past(|(flag_q & ~mask_q))));

endmodule

bind timer_ctl_bank timer_ctl_bank_chk #(
    .NCH(NCH), .HALF_POS(HALF_POS), .AW(AW), .DW(DW)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_wr    (bus_wr),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .evt_full  (evt_full),
    .evt_half  (evt_half),
    .chan_en   (chan_en),
    .chan_stop (chan_stop),
    .irq       (irq),
    .flag_q    (flag_q),
    .mask_q    (mask_q)
);

// File: tb/timer_ctl_bank_tb.sv
module timer_ctl_bank_tb;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [7:0]  evt_full = '0;
    logic [7:0]  evt_half = '0;
    logic [7:0]  chan_en;
    logic [7:0]  chan_stop;
    logic        irq;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    timer_ctl_bank u_dut (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .evt_full(evt_full),
        .evt_half(evt_half), .chan_en(chan_en), .chan_stop(chan_stop), .irq(irq)
    );

    // reference model built from the requirements
    localparam logic [31:0] IMPL = 32'h00FF00FF;
    logic [7:0]  en_m, stop_m;
    logic [31:0] flag_m, mask_m, f_nx;
    logic        irq_m;

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            en_m <= '0; stop_m <= '0; flag_m <= '0; mask_m <= IMPL; irq_m <= 1'b0;
        end else begin
            irq_m <= |(flag_m & ~mask_m);
            f_nx = flag_m;
            if (bus_wr) begin
                case (bus_addr)
                    8'h04: en_m   <= en_m | bus_wdata[7:0];
                    8'h08: en_m   <= en_m & ~bus_wdata[7:0];
                    8'h1C: stop_m <= stop_m | bus_wdata[7:0];
                    8'h2C: stop_m <= stop_m & ~bus_wdata[7:0];
                    8'h14: f_nx = f_nx | bus_wdata;
                    8'h18: f_nx = f_nx & ~bus_wdata;
                    8'h24: mask_m <= (mask_m | bus_wdata) & IMPL;
                    8'h28: mask_m <= mask_m & ~bus_wdata;
                    default: ;
                endcase
            end
            f_nx = f_nx | {8'h00, evt_half, 8'h00, evt_full};
            flag_m <= f_nx & IMPL;
        end
    end

    function automatic logic [31:0] exp_read(input logic [7:0] a);
        case (a)
            8'h00, 8'h04, 8'h08: return {24'h0, en_m};
            8'h0C, 8'h1C, 8'h2C: return {24'h0, stop_m};
            8'h10, 8'h14, 8'h18: return flag_m;
            8'h20, 8'h24, 8'h28: return mask_m;
            default:             return 32'h0;
        endcase
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d,
                      input logic [7:0] ef = 8'h0, input logic [7:0] eh = 8'h0);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d; evt_full = ef; evt_half = eh;
        @(posedge clk);
        #1;
        bus_wr = 1'b0; evt_full = '0; evt_half = '0;
    endtask

    task automatic rd(input logic [7:0] a, input logic [31:0] exp, input string req);
        @(negedge clk);
        bus_addr = a;
        #1;
        check(req, bus_rdata, exp);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: run did not complete actual=hung expected=done");
        finish_run();
    end

    initial begin
        logic [7:0] addrs [13];
        addrs = '{8'h00, 8'h04, 8'h08, 8'h0C, 8'h1C, 8'h2C, 8'h10,
                  8'h14, 8'h18, 8'h20, 8'h24, 8'h28, 8'h30};
        void'($urandom(32'h1D5E_0F2A));

        // R1 reset state, R6 alias reads return the vector
        repeat (3) @(negedge clk);
        rd(8'h00, 32'h0, "R1 enable");
        rd(8'h0C, 32'h0, "R1 halt");
        rd(8'h10, 32'h0, "R1 flag");
        rd(8'h20, 32'h00FF00FF, "R1 mask");
        check("R1 irq", {31'h0, irq}, 32'h0);
        @(negedge clk); rst_n = 1'b1;
        rd(8'h28, 32'h00FF00FF, "R6 mask via clear alias");

        // R2/R3 enable set alias
        wr(8'h04, 32'hFFFF_FFA5);
        rd(8'h00, 32'h0000_00A5, "R3 enable set");
        rd(8'h08, 32'h0000_00A5, "R6 enable read at clear alias");
        check("R10 chan_en", {24'h0, chan_en}, 32'h0000_00A5);
        // R4 clear alias
        wr(8'h08, 32'h0000_0005);
        rd(8'h04, 32'h0000_00A0, "R4 enable clear");
        // R5 base write ignored
        wr(8'h00, 32'hFFFF_FFFF);
        rd(8'h00, 32'h0000_00A0, "R5 enable base write");
        wr(8'h1C, 32'h0000_003C);
        wr(8'h0C, 32'h0000_0000);
        rd(8'h0C, 32'h0000_003C, "R5 halt base write");
        wr(8'h2C, 32'h0000_0014);
        check("R10 chan_stop", {24'h0, chan_stop}, 32'h0000_0028);

        // R6 flag unused bits, unmapped read
        wr(8'h14, 32'hFFFF_FFFF);
        rd(8'h10, 32'h00FF_00FF, "R6 flag unused bits");
        rd(8'h30, 32'h0, "R6 unmapped read");
        wr(8'h18, 32'hFFFF_FFFF);
        rd(8'h10, 32'h0, "R4 flag clear");

        // R7 channel events
        wr(8'h30, 32'h0, 8'h01, 8'h04);
        rd(8'h10, 32'h0004_0001, "R7 full and half events");

        // R9 irq lags one cycle after unmasking bit 0
        wr(8'h28, 32'h0000_0001);
        check("R9 irq not yet", {31'h0, irq}, 32'h0);
        @(posedge clk); #1;
        check("R9 irq one cycle later", {31'h0, irq}, 32'h1);

        // R8 event and clear in same cycle
        wr(8'h18, 32'h0000_0008, 8'h08, 8'h00);
        rd(8'h10, 32'h0004_0009, "R8 set wins over clear");
        wr(8'h18, 32'hFFFF_FFFF);
        @(posedge clk); #1;
        check("R9 irq drops", {31'h0, irq}, 32'h0);

        // constrained random phase, checked against model
        for (int i = 0; i < 3000; i++) begin
            @(negedge clk);
            bus_wr    = ($urandom % 2) == 0;
            bus_addr  = addrs[$urandom % 13];
            bus_wdata = $urandom;
            evt_full  = (($urandom % 4) == 0) ? 8'($urandom) : 8'h0;
            evt_half  = (($urandom % 4) == 0) ? 8'($urandom) : 8'h0;
            #1;
            check("R6 random read", bus_rdata, exp_read(bus_addr));
            check("R10 random chan_en", {24'h0, chan_en}, {24'h0, en_m});
            check("R10 random chan_stop", {24'h0, chan_stop}, {24'h0, stop_m});
            check("R9 random irq", {31'h0, irq}, {31'h0, irq_m});
        end
        @(negedge clk);
        bus_wr = 1'b0; evt_full = '0; evt_half = '0;
        finish_run();
    end

endmodule